// File: doc/BRIEF.md
# Eight-bit Arithmetic/Logic Unit with Status Flags

This block is the arithmetic and logic datapath of a small eight-bit processor core. It takes an accumulator value, a second operand, a carry input and a four-bit operation code. It returns the 8-bit result combinationally in the same cycle. A flags register is kept in the block, and it changes on the clock edge at which an operation is applied with the enable high.

The flags register holds five condition bits: sign, zero, half carry (the carry out of the low nibble), even parity and carry. Each operation class changes only its own subset of these bits. The other bits keep their previous values. A sequencer can therefore chain, for example, an increment between an addition and a conditional branch on carry without losing the carry.

Top module: `alu8_flags`

## Requirements
- R1: While reset is asserted and after it is released, `flags_o` reads 8'h02. Bit 1 is always 1, and bits 3 and 5 are always 0.
- R2: When `op_en` is low, `flags_o` does not change. `result_o` still shows the result of the operation on `op_i`.
- R3: Operation codes on `op_i` are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 compare, 10 complement, 11 rotate left, 12 rotate right. `result_o` is the matching 8-bit value, truncated modulo 256.
- R4: Add (0) and add with carry (1) compute acc+opnd, plus `cin_i` for code 1 only. CY is the carry out of bit 7. AC is the carry out of bit 3.
- R5: Subtract (2), subtract with borrow (3) and compare (9) compute acc-opnd, minus `cin_i` for code 3 only. CY is set when the subtrahend, including the borrow, exceeds acc. AC is the carry out of bit 3 of acc + ~opnd + (1 - borrow-in). Compare leaves `result_o` equal to acc and sets the flags from the difference.
- R6: For every code from 0 to 9, S is bit 7 of the computed value and Z is set when that value is zero. P is set when the value has an even number of ones. For compare, the computed value is the difference.
- R7: Increment and decrement leave CY unchanged. For increment, AC is set when the low nibble of acc is 4'hF. For decrement, AC is set when the low nibble of acc is nonzero.
- R8: AND sets AC and clears CY. OR and XOR clear both AC and CY.
- R9: Complement (10) returns ~acc and changes no flag.
- R10: Rotate left (11) moves bit 7 into bit 0. Rotate right (12) moves bit 0 into bit 7. CY takes the bit that wrapped around, and S, Z, AC and P are unchanged.
- R11: Codes 13 to 15 return acc and change no flag.
- R12: The flags byte is S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. The new flags appear on `flags_o` after the rising edge at which `op_en` was sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Apply the operation to the flags at this edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry or borrow input |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Registered flags byte |

## Verification
`result_o` depends on the current inputs with no register in its path. It is checked one nanosecond after the inputs change at a falling clock edge. The flags pass through exactly one register. Their expected value is compared at the next falling edge, after the single rising edge that loads them. The bench tracks its own copy of the flags from cycle to cycle. This makes the rules about which flags are left unchanged visible at the port. Every seventh vector is applied with the enable low, so the hold behaviour is checked between ordinary updates.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_ADC = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_SBB = 4'd3;
    localparam logic [3:0] OP_INC = 4'd4;
    localparam logic [3:0] OP_DEC = 4'd5;
    localparam logic [3:0] OP_AND = 4'd6;
    localparam logic [3:0] OP_OR  = 4'd7;
    localparam logic [3:0] OP_XOR = 4'd8;
    localparam logic [3:0] OP_CMP = 4'd9;
    localparam logic [3:0] OP_CPL = 4'd10;
    localparam logic [3:0] OP_ROL = 4'd11;
    localparam logic [3:0] OP_ROR = 4'd12;

    // bit positions inside the flags byte
    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PAR  = 2;
    localparam int FB_ONE  = 1;
    localparam int FB_CARRY = 0;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cry;
    } cond_t;

    localparam cond_t COND_RESET = '{sgn: 1'b0, zro: 1'b0, hcy: 1'b0, par: 1'b0, cry: 1'b0};
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c0_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             chalf_o,
    output logic             cout_o
);
    localparam int NIB = WIDTH / 2;
    localparam int HI  = WIDTH - NIB;

    logic [NIB:0] lo_sum;
    logic [HI:0]  hi_sum;

    always_comb begin
        lo_sum = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, c0_i};
        hi_sum = {1'b0, a_i[WIDTH-1:NIB]} + {1'b0, b_i[WIDTH-1:NIB]} + {{HI{1'b0}}, lo_sum[NIB]};
        sum_o   = {hi_sum[HI-1:0], lo_sum[NIB-1:0]};
        chalf_o = lo_sum[NIB];
        cout_o  = hi_sum[HI];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             wrap_o
);
    always_comb begin
        res_o  = a_i;
        wrap_o = 1'b0;
        case (sel_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_ROL: begin
                res_o  = {a_i[WIDTH-2:0], a_i[WIDTH-1]};
                wrap_o = a_i[WIDTH-1];
            end
            OP_ROR: begin
                res_o  = {a_i[0], a_i[WIDTH-1:1]};
                wrap_o = a_i[0];
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_statgen.sv
module alu8_statgen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val_i,
    output logic             sgn_o,
    output logic             zro_o,
    output logic             par_o
);
    logic [WIDTH:0] par_chain;

    assign par_chain[0] = 1'b1;
    for (genvar g = 0; g < WIDTH; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ val_i[g];
    end

    assign sgn_o = val_i[WIDTH-1];
    assign zro_o = (val_i == '0);
    assign par_o = par_chain[WIDTH];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_en,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] result_o,
    output logic [7:0]       flags_o
);
    logic [WIDTH-1:0] add_b;
    logic             add_c0;
    logic [WIDTH-1:0] add_sum;
    logic             add_chalf;
    logic             add_cout;
    logic [WIDTH-1:0] lg_res;
    logic             lg_wrap;
    logic [WIDTH-1:0] stat_src;
    logic             st_sgn;
    logic             st_zro;
    logic             st_par;
    logic             is_arith;
    cond_t            cond_d;
    cond_t            cond_q;

    // operand conditioning for the shared adder
    always_comb begin
        add_b  = '0;
        add_c0 = 1'b0;
        case (op_i)
            OP_ADD: begin add_b = opnd_i;  add_c0 = 1'b0;   end
            OP_ADC: begin add_b = opnd_i;  add_c0 = cin_i;  end
            OP_SUB,
            OP_CMP: begin add_b = ~opnd_i; add_c0 = 1'b1;   end
            OP_SBB: begin add_b = ~opnd_i; add_c0 = ~cin_i; end
            OP_INC: begin add_b = '0;      add_c0 = 1'b1;   end
            OP_DEC: begin add_b = '1;      add_c0 = 1'b0;   end
            default: begin add_b = '0;     add_c0 = 1'b0;   end
        endcase
    end

    alu8_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (acc_i),
        .b_i     (add_b),
        .c0_i    (add_c0),
        .sum_o   (add_sum),
        .chalf_o (add_chalf),
        .cout_o  (add_cout)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .sel_i  (op_i),
        .res_o  (lg_res),
        .wrap_o (lg_wrap)
    );

    assign is_arith = (op_i <= OP_DEC) || (op_i == OP_CMP);
    assign stat_src = is_arith ? add_sum : lg_res;

    alu8_statgen #(.WIDTH(WIDTH)) u_stat (
        .val_i (stat_src),
        .sgn_o (st_sgn),
        .zro_o (st_zro),
        .par_o (st_par)
    );

    // result selection
    always_comb begin
        if (op_i == OP_CMP) begin
            result_o = acc_i;
        end else if (is_arith) begin
            result_o = add_sum;
        end else begin
            result_o = lg_res;
        end
    end

    // next flag state
    always_comb begin
        cond_d = cond_q;
        if (op_en) begin
            case (op_i)
                OP_ADD, OP_ADC: begin
                    cond_d.sgn = st_sgn;
                    cond_d.zro = st_zro;
                    cond_d.par = st_par;
                    cond_d.hcy = add_chalf;
                    cond_d.cry = add_cout;
                end
                OP_SUB, OP_SBB, OP_CMP: begin
                    cond_d.sgn = st_sgn;
                    cond_d.zro = st_zro;
                    cond_d.par = st_par;
                    cond_d.hcy = add_chalf;
                    cond_d.cry = ~add_cout;
                end
                OP_INC, OP_DEC: begin
                    cond_d.sgn = st_sgn;
                    cond_d.zro = st_zro;
                    cond_d.par = st_par;
                    cond_d.hcy = add_chalf;
                end
                OP_AND: begin
                    cond_d.sgn = st_sgn;
                    cond_d.zro = st_zro;
                    cond_d.par = st_par;
                    cond_d.hcy = 1'b1;
                    cond_d.cry = 1'b0;
                end
                OP_OR, OP_XOR: begin
                    cond_d.sgn = st_sgn;
                    cond_d.zro = st_zro;
                    cond_d.par = st_par;
                    cond_d.hcy = 1'b0;
                    cond_d.cry = 1'b0;
                end
                OP_ROL, OP_ROR: begin
                    cond_d.cry = lg_wrap;
                end
                default: cond_d = cond_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= COND_RESET;
        end else begin
            cond_q <= cond_d;
        end
    end

    always_comb begin
        flags_o           = 8'h00;
        flags_o[FB_SIGN]  = cond_q.sgn;
        flags_o[FB_ZERO]  = cond_q.zro;
        flags_o[FB_HALF]  = cond_q.hcy;
        flags_o[FB_PAR]   = cond_q.par;
        flags_o[FB_ONE]   = 1'b1;
        flags_o[FB_CARRY] = cond_q.cry;
    end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_en,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] acc_i,
    input logic [WIDTH-1:0] opnd_i,
    input logic [WIDTH-1:0] result_o,
    input logic [7:0]       flags_o
);
    // R1: constant bits of the flags byte
    a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1] && !flags_o[3] && !flags_o[5]);

    // R2: no update without enable
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(flags_o));

    // R5: compare leaves the accumulator value on the result
    a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |-> (result_o == acc_i));

    // R6: zero flag follows the result of a logic operation
    a_r6_zero_logic: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_i >= 4'd6 && op_i <= 4'd8) |=> (flags_o[6] == ($past(result_o) == '0)));

    // R7: increment/decrement keep carry
    a_r7_incdec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_i == 4'd4 || op_i == 4'd5)) |=> (flags_o[0] == $past(flags_o[0])));

    // R8: AND result and its half-carry rule
    a_r8_and_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_i == 4'd6) |=> (flags_o[4] && !flags_o[0] && $past(result_o) == $past(acc_i & opnd_i)));

    // R9: complement changes no flag
    a_r9_cpl_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_i == 4'd10) |=> $stable(flags_o));

    // R10: rotates touch only carry
    a_r10_rot_only_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_i == 4'd11 || op_i == 4'd12)) |=> (flags_o[7:1] == $past(flags_o[7:1])));

    // R11: unused codes pass the accumulator and change nothing
    a_r11_spare_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_i >= 4'd13) |-> (result_o == acc_i) ##1 $stable(flags_o));
endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opnd_i = 8'd0;
    logic       cin_i = 1'b0;
    logic [7:0] result_o;
    logic [7:0] flags_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_flags = 8'h02;

    always #10 clk = ~clk;

    alu8_flags dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (op_en),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .cin_i    (cin_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:        return "R4";
            4'd2, 4'd3, 4'd9:  return "R5";
            4'd4, 4'd5:        return "R7";
            4'd6, 4'd7, 4'd8:  return "R8";
            4'd10:             return "R9";
            4'd11, 4'd12:      return "R10";
            default:           return "R11";
        endcase
    endfunction

    // reference: returns {result, next flags}
    function automatic logic [15:0] ref_model(input logic [3:0] op, input logic [7:0] a,
                                              input logic [7:0] b, input logic c,
                                              input logic [7:0] fin);
        int t;
        int nb;
        logic [7:0] r;
        logic [7:0] v;
        logic s, z, h, p, cy, szp;
        s = fin[7]; z = fin[6]; h = fin[4]; p = fin[2]; cy = fin[0];
        r = a; v = a; szp = 1'b0;
        nb = 255 - int'(b);
        case (op)
            4'd0, 4'd1: begin
                t = int'(a) + int'(b) + ((op == 4'd1) ? int'(c) : 0);
                r = t[7:0]; v = r; szp = 1'b1;
                cy = (t > 255);
                h = ((int'(a) % 16) + (int'(b) % 16) + ((op == 4'd1) ? int'(c) : 0)) > 15;
            end
            4'd2, 4'd3, 4'd9: begin
                t = (op == 4'd3) ? int'(c) : 0;
                v = 8'(int'(a) - int'(b) - t);
                r = (op == 4'd9) ? a : v;
                szp = 1'b1;
                cy = (int'(b) + t) > int'(a);
                h = ((int'(a) % 16) + (nb % 16) + (1 - t)) > 15;
            end
            4'd4: begin r = a + 8'd1; v = r; szp = 1'b1; h = (a[3:0] == 4'hF); end
            4'd5: begin r = a - 8'd1; v = r; szp = 1'b1; h = (a[3:0] != 4'h0); end
            4'd6: begin r = a & b; v = r; szp = 1'b1; h = 1'b1; cy = 1'b0; end
            4'd7: begin r = a | b; v = r; szp = 1'b1; h = 1'b0; cy = 1'b0; end
            4'd8: begin r = a ^ b; v = r; szp = 1'b1; h = 1'b0; cy = 1'b0; end
            4'd10: r = ~a;
            4'd11: begin r = {a[6:0], a[7]}; cy = a[7]; end
            4'd12: begin r = {a[0], a[7:1]}; cy = a[0]; end
            default: r = a;
        endcase
        if (szp) begin
            s = v[7];
            z = (v == 8'd0);
            p = ($countones(v) % 2) == 0;
        end
        return {r, s, z, 1'b0, h, 1'b0, p, 1'b1, cy};
    endfunction

    // called just after a falling edge; ends at the next falling edge
    task automatic apply_vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic c, input logic en);
        logic [15:0] m;
        op_i = op; acc_i = a; opnd_i = b; cin_i = c; op_en = en;
        m = ref_model(op, a, b, c, exp_flags);
        #1;
        n_vec++;
        if (result_o !== m[15:8]) begin
            n_bad++;
            $display("FAIL %s R3 result op=%0d a=%h b=%h c=%0d: got %h expected %h",
                     tag_of(op), op, a, b, c, result_o, m[15:8]);
        end
        if (en) exp_flags = m[7:0];
        @(negedge clk);
        n_vec++;
        if (flags_o !== exp_flags) begin
            n_bad++;
            $display("FAIL %s R6 R12 %s flags op=%0d a=%h b=%h c=%0d en=%0d: got %h expected %h",
                     tag_of(op), en ? "" : "R2", op, a, b, c, en, flags_o, exp_flags);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int idx;
        idx = 0;
        repeat (2) @(negedge clk);
        n_vec++;
        if (flags_o !== 8'h02) begin
            n_bad++;
            $display("FAIL R1 flags in reset: got %h expected 02", flags_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (flags_o !== 8'h02) begin
            n_bad++;
            $display("FAIL R1 flags after reset: got %h expected 02", flags_o);
        end
        // directed corners
        apply_vec(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1);  // R4 full carry, zero
        apply_vec(4'd0, 8'h0F, 8'h01, 1'b0, 1'b1);  // R4 half carry only
        apply_vec(4'd3, 8'h00, 8'h00, 1'b1, 1'b1);  // R5 borrow from carry-in
        apply_vec(4'd9, 8'h10, 8'h10, 1'b0, 1'b1);  // R5 equal compare
        apply_vec(4'd4, 8'hFF, 8'h00, 1'b0, 1'b1);  // R7 wrap, CY kept
        apply_vec(4'd5, 8'h00, 8'h00, 1'b0, 1'b1);  // R7 underflow
        apply_vec(4'd11, 8'h80, 8'h00, 1'b0, 1'b1); // R10
        apply_vec(4'd12, 8'h01, 8'h00, 1'b0, 1'b0); // R2 idle
        // sweep
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 6; k++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] b;
                        case (k)
                            0: b = 8'h00;
                            1: b = 8'(a);
                            2: b = 8'hFF;
                            default: b = 8'((a * 29 + k * 83 + op * 7) % 256);
                        endcase
                        apply_vec(4'(op), 8'(a), b, c[0], (idx % 7) != 3);
                        idx++;
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule